// File: doc/BRIEF.md
# Relative Branch and Counted-Loop Resolver

This block settles where a 16-bit, word-addressed processor goes next after a short relative control-transfer instruction. Each cycle it looks at the instruction word, the program counter of that instruction, the four status flags (minus, overflow, zero, carry) and one register value. From these it works out whether control leaves the sequential path and what the next program counter is.

Two opcode groups are handled. The first is a flag-tested branch whose condition field chooses one of eight tests, some of them compound. One encoding of the always-true test never matches and so acts as a no-operation. Its opposite polarity is an unconditional jump. The second group is a counted-loop instruction. It decrements any one of sixteen registers, requests the write-back of the result, and branches while the result is non-zero. Both groups use the same 8-bit signed word offset path, which is applied relative to the following word.

The register file read index is given out combinationally, so the register file can return the loop counter in the same cycle. The results appear on registered outputs one clock after the inputs are presented. Every instruction outside the two groups yields the sequential address and no write.

Top module: `brl_unit`

## Requirements
- R1: While reset is asserted, and after an asynchronous reset assertion, taken_o, next_pc_o, wb_en_o, wb_idx_o and wb_data_o are all zero.
- R2: For an instruction with bits [15:12]=0100, bits [11:9] select the test (0: always true, 1: Z or C, 2: M xor O, 3: Z or (M xor O), 4: C, 5: Z, 6: O, 7: M). Bit 8 is the required value, and the branch is taken exactly when the test result equals bit 8.
- R3: Instruction bits [15:8]=0x40 is a no-operation. It is never taken and gives next_pc_o = pc+1, whatever the flags and offset are.
- R4: Instruction bits [15:8]=0x41 is always taken, whatever the flags are.
- R5: A taken transfer gives next_pc_o = pc + 1 + sign-extended bits [7:0], modulo 2^16.
- R6: A not-taken transfer gives next_pc_o = pc+1. The branch group never raises wb_en_o.
- R7: For bits [15:12]=0101, wb_en_o is 1, wb_idx_o is bits [11:8], and wb_data_o is the register value minus one, modulo 2^16.
- R8: The counted-loop instruction is taken exactly when the decremented value is non-zero. A value of 0x0001 falls through, and 0x0000 wraps to 0xFFFF and is taken.
- R9: Any other value of bits [15:12] gives taken_o=0, next_pc_o=pc+1 and wb_en_o=0.
- R10: rd_idx_o equals instruction bits [11:8] combinationally, in the same cycle.
- R11: Registered outputs change only at the rising clock edge after the inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word being resolved |
| pc_i | input | 16 | Address of that instruction |
| flag_m_i | input | 1 | Minus flag |
| flag_o_i | input | 1 | Overflow flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| reg_val_i | input | 16 | Value of the register selected by rd_idx_o |
| rd_idx_o | output | 4 | Register read index for the loop counter |
| taken_o | output | 1 | Control leaves the sequential path |
| next_pc_o | output | 16 | Next program counter |
| wb_en_o | output | 1 | Register write-back request |
| wb_idx_o | output | 4 | Register to write |
| wb_data_o | output | 16 | Decremented value to write |

## Verification
The flag-tested branch is driven with all sixteen flag combinations under each of the seven real tests in both polarities. This separates the compound tests from their single-flag parts and catches any swap between selectors. The no-operation and jump encodings are driven across all flag patterns to show that they ignore the flags. Offsets of +127, -128 and -1, together with program counters at the top and bottom of the address space, show the sign extension and the wrap-around. Loop counts of 5, 1 and 0 on different registers tell apart the taken path, the fall-through path and the wrap to 0xFFFF. Opcodes from the other groups, carrying bit patterns that would branch if they were decoded, confirm that nothing leaks through.

// File: rtl/brl_pkg.sv
package brl_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned OFF_W   = 8;
  localparam int unsigned RIDX_W  = 4;
  localparam int unsigned OPC_W   = 4;
  localparam int unsigned SEL_W   = 3;

  localparam logic [OPC_W-1:0] OPC_BRANCH = 4'b0100;
  localparam logic [OPC_W-1:0] OPC_DLOOP  = 4'b0101;

  typedef enum logic [SEL_W-1:0] {
    SEL_ONE      = 3'd0,
    SEL_Z_OR_C   = 3'd1,
    SEL_M_XOR_O  = 3'd2,
    SEL_Z_OR_MXO = 3'd3,
    SEL_C        = 3'd4,
    SEL_Z        = 3'd5,
    SEL_O        = 3'd6,
    SEL_M        = 3'd7
  } cond_sel_e;

  typedef enum logic [1:0] {
    KIND_OTHER  = 2'd0,
    KIND_BRANCH = 2'd1,
    KIND_DLOOP  = 2'd2
  } kind_e;

  typedef struct packed {
    logic m;
    logic o;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/brl_decode.sv
module brl_decode
  import brl_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output kind_e              kind,
  output cond_sel_e          sel,
  output logic               want,
  output logic [OFF_W-1:0]   off,
  output logic [RIDX_W-1:0]  ridx
);
  logic [OPC_W-1:0] opc;

  assign opc  = instr[INSTR_W-1 -: OPC_W];
  assign sel  = cond_sel_e'(instr[11:9]);
  assign want = instr[8];
  assign off  = instr[OFF_W-1:0];
  assign ridx = instr[11:8];

  always_comb begin
    unique case (opc)
      OPC_BRANCH: kind = KIND_BRANCH;
      OPC_DLOOP:  kind = KIND_DLOOP;
      default:    kind = KIND_OTHER;
    endcase
  end
endmodule

// File: rtl/brl_cond_eval.sv
module brl_cond_eval
  import brl_pkg::*;
(
  input  cond_sel_e sel,
  input  flags_t    fl,
  output logic      holds
);
  logic lt;

  assign lt = fl.m ^ fl.o;

  always_comb begin
    unique case (sel)
      SEL_ONE:      holds = 1'b1;
      SEL_Z_OR_C:   holds = fl.z | fl.c;
      SEL_M_XOR_O:  holds = lt;
      SEL_Z_OR_MXO: holds = fl.z | lt;
      SEL_C:        holds = fl.c;
      SEL_Z:        holds = fl.z;
      SEL_O:        holds = fl.o;
      SEL_M:        holds = fl.m;
      default:      holds = 1'b0;
    endcase
  end
endmodule

// File: rtl/brl_target.sv
module brl_target #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 8
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] jump_pc
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
    end else begin : g_trunc
      assign off_ext = off[ADDR_W-1:0];
    end
  endgenerate

  assign seq_pc  = pc + ADDR_W'(1);
  assign jump_pc = seq_pc + off_ext;
endmodule

// File: rtl/brl_unit.sv
module brl_unit
  import brl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic                flag_m_i,
  input  logic                flag_o_i,
  input  logic                flag_z_i,
  input  logic                flag_c_i,
  input  logic [DATA_W-1:0]   reg_val_i,
  output logic [RIDX_W-1:0]   rd_idx_o,
  output logic                taken_o,
  output logic [ADDR_W-1:0]   next_pc_o,
  output logic                wb_en_o,
  output logic [RIDX_W-1:0]   wb_idx_o,
  output logic [DATA_W-1:0]   wb_data_o
);
  localparam int unsigned SYNC_STAGES = 2;

  // reset: asserted at once, released through a short flop chain
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC_STAGES-1];

  // decode and evaluate
  kind_e             kind;
  cond_sel_e         sel;
  logic              want;
  logic [OFF_W-1:0]  off;
  logic [RIDX_W-1:0] ridx;
  logic              holds;
  flags_t            fl;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] jump_pc;

  assign fl = '{m: flag_m_i, o: flag_o_i, z: flag_z_i, c: flag_c_i};

  brl_decode u_dec (
    .instr (instr_i),
    .kind  (kind),
    .sel   (sel),
    .want  (want),
    .off   (off),
    .ridx  (ridx)
  );

  brl_cond_eval u_cond (
    .sel   (sel),
    .fl    (fl),
    .holds (holds)
  );

  brl_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
    .pc      (pc_i),
    .off     (off),
    .seq_pc  (seq_pc),
    .jump_pc (jump_pc)
  );

  assign rd_idx_o = ridx;

  // next-state
  logic              taken_d;
  logic [ADDR_W-1:0] next_pc_d;
  logic              wb_en_d;
  logic [RIDX_W-1:0] wb_idx_d;
  logic [DATA_W-1:0] wb_data_d;
  logic [DATA_W-1:0] dec_val;
  logic              upd_en;

  assign dec_val = reg_val_i - DATA_W'(1);
  assign upd_en  = 1'b1;

  always_comb begin
    taken_d   = 1'b0;
    wb_en_d   = 1'b0;
    wb_idx_d  = '0;
    wb_data_d = '0;
    unique case (kind)
      KIND_BRANCH: taken_d = (holds == want);
      KIND_DLOOP: begin
        taken_d   = |dec_val;
        wb_en_d   = 1'b1;
        wb_idx_d  = ridx;
        wb_data_d = dec_val;
      end
      default: taken_d = 1'b0;
    endcase
    next_pc_d = taken_d ? jump_pc : seq_pc;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      taken_o   <= 1'b0;
      next_pc_o <= '0;
      wb_en_o   <= 1'b0;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
    end else if (upd_en) begin
      taken_o   <= taken_d;
      next_pc_o <= next_pc_d;
      wb_en_o   <= wb_en_d;
      wb_idx_o  <= wb_idx_d;
      wb_data_o <= wb_data_d;
    end
  end
endmodule

// File: rtl/brl_unit_chk.sv
module brl_unit_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [15:0]       instr_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [DATA_W-1:0] reg_val_i,
  input logic              taken_o,
  input logic [ADDR_W-1:0] next_pc_o,
  input logic              wb_en_o,
  input logic [DATA_W-1:0] wb_data_o
);
  AST_NOP_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && $past(instr_i[15:8]) == 8'h40) |-> (!taken_o && next_pc_o == $past(pc_i) + ADDR_W'(1))); // R3

  AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && $past(instr_i[15:8]) == 8'h41) |-> taken_o); // R4

  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && taken_o) |->
      (next_pc_o == $past(pc_i) + ADDR_W'(1) + {{(ADDR_W-8){$past(instr_i[7])}}, $past(instr_i[7:0])})); // R5

  AST_FALLTHROUGH_SEQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && !taken_o) |-> (next_pc_o == $past(pc_i) + ADDR_W'(1))); // R6

  AST_WB_ONLY_LOOP: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && wb_en_o) |-> ($past(instr_i[15:12]) == 4'b0101)); // R7

  AST_WB_DECREMENT: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && wb_en_o) |-> (wb_data_o == $past(reg_val_i) - DATA_W'(1))); // R7

  AST_LOOP_ZERO_EXITS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wb_en_o && wb_data_o == '0) |-> !taken_o); // R8

  AST_OTHER_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && $past(instr_i[15:13]) != 3'b010) |-> (!taken_o && !wb_en_o)); // R9
endmodule

bind brl_unit brl_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .instr_i   (instr_i),
  .pc_i      (pc_i),
  .reg_val_i (reg_val_i),
  .taken_o   (taken_o),
  .next_pc_o (next_pc_o),
  .wb_en_o   (wb_en_o),
  .wb_data_o (wb_data_o)
);

// File: tb/brl_unit_bench.sv
`timescale 1ns/1ps
module brl_unit_bench;
  logic        clk;
  logic        rst_n;
  logic [15:0] instr_i;
  logic [15:0] pc_i;
  logic        flag_m_i, flag_o_i, flag_z_i, flag_c_i;
  logic [15:0] reg_val_i;
  logic [3:0]  rd_idx_o;
  logic        taken_o;
  logic [15:0] next_pc_o;
  logic        wb_en_o;
  logic [3:0]  wb_idx_o;
  logic [15:0] wb_data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  brl_unit u_brl_unit (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .pc_i(pc_i),
    .flag_m_i(flag_m_i), .flag_o_i(flag_o_i), .flag_z_i(flag_z_i), .flag_c_i(flag_c_i),
    .reg_val_i(reg_val_i), .rd_idx_o(rd_idx_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
    .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // flags packed as {m,o,z,c}
  function automatic logic test_of(input logic [2:0] sel, input logic [3:0] f);
    logic m, o, z, c;
    {m, o, z, c} = f;
    case (sel)
      3'd0: return 1'b1;
      3'd1: return z | c;
      3'd2: return m ^ o;
      3'd3: return z | (m ^ o);
      3'd4: return c;
      3'd5: return z;
      3'd6: return o;
      default: return m;
    endcase
  endfunction

  function automatic logic [15:0] target_of(input logic [15:0] pc, input logic [7:0] off);
    return pc + 16'd1 + {{8{off[7]}}, off};
  endfunction

  // drive at a falling edge, results are registered at the next rising edge,
  // sampled at the falling edge after it
  task automatic apply(input logic [15:0] ins, input logic [15:0] pc,
                       input logic [3:0] f, input logic [15:0] rv);
    @(negedge clk);
    instr_i = ins; pc_i = pc; reg_val_i = rv;
    {flag_m_i, flag_o_i, flag_z_i, flag_c_i} = f;
    #1;
    chk("R10", "rd_idx_o", 32'(rd_idx_o), 32'(ins[11:8]));
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "taken_o in reset", 32'(taken_o), 0);
    chk("R1", "next_pc_o in reset", 32'(next_pc_o), 0);
    chk("R1", "wb_en_o in reset", 32'(wb_en_o), 0);
    chk("R1", "wb_idx_o in reset", 32'(wb_idx_o), 0);
    chk("R1", "wb_data_o in reset", 32'(wb_data_o), 0);
  endtask

  task automatic t_nop;
    for (int f = 0; f < 16; f++) begin
      apply(16'h4000 | 16'(8'h20 + f), 16'h0300, 4'(f), 16'h0000);
      chk("R3", "nop taken_o", 32'(taken_o), 0);
      chk("R3", "nop next_pc_o", 32'(next_pc_o), 32'h0301);
    end
  endtask

  task automatic t_jump;
    for (int f = 0; f < 16; f++) begin
      apply(16'h41F0, 16'h0400, 4'(f), 16'h0000);
      chk("R4", "jump taken_o", 32'(taken_o), 1);
      chk("R4", "jump next_pc_o", 32'(next_pc_o), 32'(target_of(16'h0400, 8'hF0)));
    end
  endtask

  task automatic t_conditions;
    for (int s = 1; s < 8; s++)
      for (int v = 0; v < 2; v++)
        for (int f = 0; f < 16; f++) begin
          logic [15:0] ins;
          logic        exp_t;
          ins   = {4'b0100, 3'(s), 1'(v), 8'h11};
          exp_t = (test_of(3'(s), 4'(f)) == 1'(v));
          apply(ins, 16'h2000, 4'(f), 16'h0000);
          chk("R2", $sformatf("taken sel=%0d v=%0d f=%0h", s, v, f), 32'(taken_o), 32'(exp_t));
          chk("R6", "branch next_pc_o",
              32'(next_pc_o), exp_t ? 32'(target_of(16'h2000, 8'h11)) : 32'h2001);
          chk("R6", "branch wb_en_o", 32'(wb_en_o), 0);
        end
  endtask

  task automatic t_offsets;
    apply(16'h417F, 16'h1000, 4'h0, 16'h0);
    chk("R5", "offset +127", 32'(next_pc_o), 32'h1080);
    apply(16'h4180, 16'h1000, 4'h0, 16'h0);
    chk("R5", "offset -128", 32'(next_pc_o), 32'h0F81);
    apply(16'h41FF, 16'h1000, 4'h0, 16'h0);
    chk("R5", "offset -1", 32'(next_pc_o), 32'h1000);
    apply(16'h4105, 16'hFFFF, 4'h0, 16'h0);
    chk("R5", "wrap at top", 32'(next_pc_o), 32'h0005);
    apply(16'h4180, 16'h0000, 4'h0, 16'h0);
    chk("R5", "wrap at bottom", 32'(next_pc_o), 32'hFF81);
  endtask

  task automatic t_dloop;
    apply(16'h53FC, 16'h0100, 4'h0, 16'h0005);
    chk("R7", "wb_en_o", 32'(wb_en_o), 1);
    chk("R7", "wb_idx_o", 32'(wb_idx_o), 3);
    chk("R7", "wb_data_o", 32'(wb_data_o), 4);
    chk("R8", "count 5 taken", 32'(taken_o), 1);
    chk("R8", "count 5 target", 32'(next_pc_o), 32'h00FD);
    apply(16'h5F10, 16'h0100, 4'hF, 16'h0001);
    chk("R7", "wb_idx_o r15", 32'(wb_idx_o), 15);
    chk("R7", "wb_data_o zero", 32'(wb_data_o), 0);
    chk("R8", "count 1 falls through", 32'(taken_o), 0);
    chk("R8", "count 1 next_pc_o", 32'(next_pc_o), 32'h0101);
    apply(16'h5002, 16'h0100, 4'h0, 16'h0000);
    chk("R7", "wb_idx_o r0", 32'(wb_idx_o), 0);
    chk("R8", "wrap data", 32'(wb_data_o), 32'hFFFF);
    chk("R8", "wrap taken", 32'(taken_o), 1);
    chk("R8", "wrap target", 32'(next_pc_o), 32'h0103);
  endtask

  task automatic t_other;
    logic [3:0] opcs [6] = '{4'h0, 4'h3, 4'h6, 4'h7, 4'hC, 4'hF};
    foreach (opcs[i]) begin
      apply({opcs[i], 12'h140}, 16'h0700, 4'hF, 16'h0009);
      chk("R9", "other taken_o", 32'(taken_o), 0);
      chk("R9", "other next_pc_o", 32'(next_pc_o), 32'h0701);
      chk("R9", "other wb_en_o", 32'(wb_en_o), 0);
    end
  endtask

  task automatic t_latency;
    apply(16'h4110, 16'h0500, 4'h0, 16'h0);
    @(negedge clk);
    instr_i = 16'h4000; pc_i = 16'h0900;
    #1;
    chk("R11", "taken_o holds before edge", 32'(taken_o), 1);
    chk("R11", "next_pc_o holds before edge", 32'(next_pc_o), 32'h0511);
    @(negedge clk);
    chk("R11", "next_pc_o after edge", 32'(next_pc_o), 32'h0901);
  endtask

  task automatic t_async_reset;
    apply(16'h5405, 16'h0100, 4'h0, 16'h0007);
    #1 rst_n = 1'b0;
    #1;
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    instr_i = 16'h0; pc_i = 16'h0; reg_val_i = 16'h0;
    {flag_m_i, flag_o_i, flag_z_i, flag_c_i} = 4'h0;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_nop();
    t_jump();
    t_conditions();
    t_offsets();
    t_dloop();
    t_other();
    t_latency();
    t_async_reset();
    t_offsets();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule